// File: doc/BRIEF.md
# Power Island Ordering Monitor

This block watches the supply states of a parameterised set of power islands. Each island reports a two-bit state code. On every clock edge where sampling is enabled, the block updates what it has learned about every pair of islands.

For each pair it tracks four things:

- whether one island has always been at least as powered as the other, which means it ranks above;
- whether the two have always been identical, which means they are equivalent;
- whether each has been seen off while the other was on, which means they are disjoint;
- or whether neither ordering holds.

Alongside the states, the block takes a connection matrix. The matrix says which islands send control-type signals (clock, clock enable, reset, power gate, isolation enable, scan enable, restore) into which other islands. A connection that runs from a strictly lower-ranked island into a higher-ranked one is a fault. So is any connection between two disjoint islands. Each fault sets a sticky violation flag for that connection.

Each unordered pair of islands has its own small state machine. The machine has four states:

- `ORD_EQUAL`: the pair is equivalent and each island ranks above the other.
- `ORD_A_ABOVE`: the lower-indexed island ranks strictly above the other.
- `ORD_B_ABOVE`: the higher-indexed island ranks strictly above the other.
- `ORD_CROSSED`: neither island ranks above the other.

The machine moves between these states as follows:

- `EQUAL_TO_A` fires from `ORD_EQUAL` on a sample where the lower-indexed island is higher.
- `EQUAL_TO_B` fires from `ORD_EQUAL` on a sample where the higher-indexed island is higher.
- `A_TO_CROSSED` fires from `ORD_A_ABOVE` on a sample where the higher-indexed island is higher.
- `B_TO_CROSSED` fires from `ORD_B_ABOVE` on a sample where the lower-indexed island is higher.
- `ORD_CROSSED` is terminal until a clear.

Two sticky "seen off while the other is on" bits, one per direction, run alongside the machine. The pair is disjoint when both bits are set. A synchronous clear returns all pairs to `ORD_EQUAL` and empties every sticky flag.

Top module: `island_order_monitor`

## Requirements
- R1: Each island's state code is 2'b10 On, 2'b01 Standby, 2'b00 Off; 2'b11 is illegal. A sampled illegal code sets that island's sticky bit in `illegal_o`, and a sample in which either island of a pair is illegal leaves that pair's history unchanged.
- R2: On a clock edge with `clear_i` high, the following happen, regardless of `sample_en_i`:
  - every off-diagonal bit of `rank_over_o` and `equiv_o` becomes 1;
  - all bits of `disjoint_o`, `viol_order_o`, `viol_disj_o` and `illegal_o` become 0;
  - diagonal bits of `rank_over_o` and `equiv_o` are always 0.
- R3: Bit i*N+j of `rank_over_o` (island i ranks above island j) clears after any sample with state(i) < state(j), using On > Standby > Off. It stays clear until the next clear.
- R4: Bits i*N+j and j*N+i of `equiv_o` clear after any sample in which the two islands' states differ, and stay clear until the next clear.
- R5: `disjoint_o` bits i*N+j and j*N+i set once two samples have been seen: one with i Off and j On, and one with i On and j Off. Standby never counts towards this condition.
- R6: No relation or illegal flag changes on an edge where `sample_en_i` is low.
- R7: Bit i*N+j of `viol_order_o` sets when bit i*N+j of `ctrl_conn_i` is high (island i drives a control signal into island j) while j ranks above i and i does not rank above j. The bit is sticky until clear.
- R8: Bit i*N+j of `viol_disj_o` sets when bit i*N+j of `ctrl_conn_i` is high while the pair is disjoint. The bit is sticky until clear.
- R9: Diagonal bits of `ctrl_conn_i` never raise a violation, and neither does a connection between equivalent islands.
- R10: Relation outputs reflect a sample one edge after it is taken. A violation flag sets on the edge after the relation outputs that cause it are visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clear_i | input | 1 | Synchronous active-high clear of all history and flags |
| sample_en_i | input | 1 | Take a sample of island states on this edge |
| isl_state_i | input | 2*N_ISL | State code of island k at bits [2k+1:2k] |
| ctrl_conn_i | input | N_ISL*N_ISL | Bit i*N+j: island i sends control into island j |
| rank_over_o | output | N_ISL*N_ISL | Bit i*N+j: island i ranks above island j |
| equiv_o | output | N_ISL*N_ISL | Bit i*N+j: islands i and j equivalent |
| disjoint_o | output | N_ISL*N_ISL | Bit i*N+j: islands i and j disjoint |
| viol_order_o | output | N_ISL*N_ISL | Sticky: connection i->j goes from lower to higher rank |
| viol_disj_o | output | N_ISL*N_ISL | Sticky: connection i->j joins disjoint islands |
| illegal_o | output | N_ISL | Sticky: island k showed code 2'b11 |

## Verification
The hardest situation to reach is a disjoint pair. It needs two separate samples with opposite Off/On combinations, and those samples must avoid Standby, which pushes a pair to `ORD_CROSSED` without making it disjoint. The bench drives both orders on one pair and then a Standby-only crossing on the same pair after a clear, so that both outcomes are compared. Violation timing is also reached on purpose: the connection is held in place before the sample that breaks equivalence, which shows the one-edge lag between the relation change and the violation flag.

// File: rtl/island_order_pkg.sv
package island_order_pkg;

    // Power state codes; numeric order matches power order.
    typedef enum logic [1:0] {
        PS_OFF  = 2'b00,
        PS_STBY = 2'b01,
        PS_ON   = 2'b10,
        PS_BAD  = 2'b11
    } pwr_code_e;

    // Ordering knowledge held for one unordered pair (a = lower index).
    typedef enum logic [1:0] {
        ORD_EQUAL   = 2'b00,
        ORD_A_ABOVE = 2'b01,
        ORD_B_ABOVE = 2'b10,
        ORD_CROSSED = 2'b11
    } pair_ord_e;

endpackage

// File: rtl/isl_code_guard.sv
module isl_code_guard
    import island_order_pkg::*;
#(
    parameter int N_ISL = 4
) (
    input  logic               clk,
    input  logic               clear,
    input  logic               sample_en,
    input  logic [2*N_ISL-1:0] codes,
    output logic [N_ISL-1:0]   legal,
    output logic [N_ISL-1:0]   bad_q
);

    for (genvar k = 0; k < N_ISL; k++) begin : g_code
        assign legal[k] = (codes[2*k +: 2] != PS_BAD);
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            bad_q <= '0;
        end else if (sample_en) begin
            bad_q <= bad_q | ~legal;
        end
    end

    AST_BAD_STICKY: assert property (@(posedge clk) disable iff (clear)
        (bad_q != '0) |=> ((bad_q & $past(bad_q)) == $past(bad_q))); // R1

    AST_BAD_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (clear)
        !sample_en |=> $stable(bad_q)); // R6

endmodule

// File: rtl/isl_pair_tracker.sv
module isl_pair_tracker
    import island_order_pkg::*;
(
    input  logic       clk,
    input  logic       clear,
    input  logic       smp,
    input  logic [1:0] code_a,
    input  logic [1:0] code_b,
    output logic       a_over_b,
    output logic       b_over_a,
    output logic       same,
    output logic       disjoint
);

    pair_ord_e ord_q, ord_d;
    logic      a_off_b_on_q;
    logic      b_off_a_on_q;
    logic      a_hi, b_hi;

    assign a_hi = (code_a > code_b);
    assign b_hi = (code_b > code_a);

    // State register
    always_ff @(posedge clk) begin
        if (clear) begin
            ord_q        <= ORD_EQUAL;
            a_off_b_on_q <= 1'b0;
            b_off_a_on_q <= 1'b0;
        end else begin
            ord_q <= ord_d;
            if (smp && code_a == PS_OFF && code_b == PS_ON) a_off_b_on_q <= 1'b1;
            if (smp && code_b == PS_OFF && code_a == PS_ON) b_off_a_on_q <= 1'b1;
        end
    end

    // Transitions
    always_comb begin
        ord_d = ord_q;
        if (smp) begin
            unique case (ord_q)
                ORD_EQUAL: begin
                    if (a_hi)      ord_d = ORD_A_ABOVE;   // EQUAL_TO_A
                    else if (b_hi) ord_d = ORD_B_ABOVE;   // EQUAL_TO_B
                end
                ORD_A_ABOVE: if (b_hi) ord_d = ORD_CROSSED; // A_TO_CROSSED
                ORD_B_ABOVE: if (a_hi) ord_d = ORD_CROSSED; // B_TO_CROSSED
                ORD_CROSSED: ord_d = ORD_CROSSED;
            endcase
        end
    end

    // Outputs
    always_comb begin
        a_over_b = 1'b0;
        b_over_a = 1'b0;
        same     = 1'b0;
        unique case (ord_q)
            ORD_EQUAL: begin
                a_over_b = 1'b1;
                b_over_a = 1'b1;
                same     = 1'b1;
            end
            ORD_A_ABOVE: a_over_b = 1'b1;
            ORD_B_ABOVE: b_over_a = 1'b1;
            ORD_CROSSED: ;
        endcase
    end

    assign disjoint = a_off_b_on_q & b_off_a_on_q;

    AST_CROSSED_HOLDS: assert property (@(posedge clk) disable iff (clear)
        (ord_q == ORD_CROSSED) |=> (ord_q == ORD_CROSSED)); // R3

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (clear)
        !smp |=> $stable(ord_q)); // R6

    AST_DISJ_CROSSED: assert property (@(posedge clk) disable iff (clear)
        disjoint |-> (ord_q == ORD_CROSSED)); // R5

    AST_B_HIGH_KILLS_A: assert property (@(posedge clk) disable iff (clear)
        (smp && b_hi) |=> !a_over_b); // R3

endmodule

// File: rtl/isl_ctrl_checker.sv
module isl_ctrl_checker #(
    parameter int N_ISL = 4
) (
    input  logic                     clk,
    input  logic                     clear,
    input  logic [N_ISL*N_ISL-1:0]   conn,
    input  logic [N_ISL*N_ISL-1:0]   rank,
    input  logic [N_ISL*N_ISL-1:0]   disj,
    output logic [N_ISL*N_ISL-1:0]   viol_order_q,
    output logic [N_ISL*N_ISL-1:0]   viol_disj_q
);

    localparam int NN = N_ISL * N_ISL;

    logic [NN-1:0] ord_hit;
    logic [NN-1:0] disj_hit;

    for (genvar i = 0; i < N_ISL; i++) begin : g_src
        for (genvar j = 0; j < N_ISL; j++) begin : g_dst
            if (i == j) begin : g_diag
                assign ord_hit[i*N_ISL+j]  = 1'b0;
                assign disj_hit[i*N_ISL+j] = 1'b0;
            end else begin : g_pair
                assign ord_hit[i*N_ISL+j]  = conn[i*N_ISL+j] & rank[j*N_ISL+i]
                                           & ~rank[i*N_ISL+j];
                assign disj_hit[i*N_ISL+j] = conn[i*N_ISL+j] & disj[i*N_ISL+j];

                AST_ORDER_CAUSE: assert property (@(posedge clk) disable iff (clear)
                    $rose(viol_order_q[i*N_ISL+j]) |->
                    $past(conn[i*N_ISL+j] && rank[j*N_ISL+i] && !rank[i*N_ISL+j])); // R7
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clear) begin
            viol_order_q <= '0;
            viol_disj_q  <= '0;
        end else begin
            viol_order_q <= viol_order_q | ord_hit;
            viol_disj_q  <= viol_disj_q | disj_hit;
        end
    end

    AST_ORDER_STICKY: assert property (@(posedge clk) disable iff (clear)
        (viol_order_q != '0) |=> ((viol_order_q & $past(viol_order_q)) == $past(viol_order_q))); // R7

    AST_DISJ_STICKY: assert property (@(posedge clk) disable iff (clear)
        (viol_disj_q != '0) |=> ((viol_disj_q & $past(viol_disj_q)) == $past(viol_disj_q))); // R8

endmodule

// File: rtl/island_order_monitor.sv
module island_order_monitor
    import island_order_pkg::*;
#(
    parameter int N_ISL = 4   // 2 to 8 islands
) (
    input  logic                   clk,
    input  logic                   clear_i,
    input  logic                   sample_en_i,
    input  logic [2*N_ISL-1:0]     isl_state_i,
    input  logic [N_ISL*N_ISL-1:0] ctrl_conn_i,
    output logic [N_ISL*N_ISL-1:0] rank_over_o,
    output logic [N_ISL*N_ISL-1:0] equiv_o,
    output logic [N_ISL*N_ISL-1:0] disjoint_o,
    output logic [N_ISL*N_ISL-1:0] viol_order_o,
    output logic [N_ISL*N_ISL-1:0] viol_disj_o,
    output logic [N_ISL-1:0]       illegal_o
);

    logic [N_ISL-1:0] legal;

    isl_code_guard #(.N_ISL(N_ISL)) u_guard (
        .clk       (clk),
        .clear     (clear_i),
        .sample_en (sample_en_i),
        .codes     (isl_state_i),
        .legal     (legal),
        .bad_q     (illegal_o)
    );

    for (genvar a = 0; a < N_ISL; a++) begin : g_a
        for (genvar b = 0; b < N_ISL; b++) begin : g_b
            if (a == b) begin : g_self
                assign rank_over_o[a*N_ISL+b] = 1'b0;
                assign equiv_o[a*N_ISL+b]     = 1'b0;
                assign disjoint_o[a*N_ISL+b]  = 1'b0;
            end else if (b > a) begin : g_pair
                logic a_ov, b_ov, eq, dj;

                isl_pair_tracker u_pair (
                    .clk      (clk),
                    .clear    (clear_i),
                    .smp      (sample_en_i & legal[a] & legal[b]),
                    .code_a   (isl_state_i[2*a +: 2]),
                    .code_b   (isl_state_i[2*b +: 2]),
                    .a_over_b (a_ov),
                    .b_over_a (b_ov),
                    .same     (eq),
                    .disjoint (dj)
                );

                assign rank_over_o[a*N_ISL+b] = a_ov;
                assign rank_over_o[b*N_ISL+a] = b_ov;
                assign equiv_o[a*N_ISL+b]     = eq;
                assign equiv_o[b*N_ISL+a]     = eq;
                assign disjoint_o[a*N_ISL+b]  = dj;
                assign disjoint_o[b*N_ISL+a]  = dj;

                AST_ILLEGAL_FREEZES: assert property (@(posedge clk) disable iff (clear_i)
                    (!legal[a] || !legal[b]) |=> ($stable(rank_over_o[a*N_ISL+b])
                        && $stable(rank_over_o[b*N_ISL+a]) && $stable(equiv_o[a*N_ISL+b]))); // R1
            end
        end
    end

    isl_ctrl_checker #(.N_ISL(N_ISL)) u_ctrl (
        .clk          (clk),
        .clear        (clear_i),
        .conn         (ctrl_conn_i),
        .rank         (rank_over_o),
        .disj         (disjoint_o),
        .viol_order_q (viol_order_o),
        .viol_disj_q  (viol_disj_o)
    );

endmodule

// File: tb/island_order_monitor_tb.sv
`timescale 1ns/1ps
module island_order_monitor_tb;

    localparam int N  = 4;
    localparam int NN = N * N;
    localparam logic [1:0] OFF = 2'b00, SB = 2'b01, ON = 2'b10, BAD = 2'b11;

    logic            clk = 1'b0;
    logic            clear_i;
    logic            sample_en_i;
    logic [2*N-1:0]  isl_state_i;
    logic [NN-1:0]   ctrl_conn_i;
    logic [NN-1:0]   rank_over_o, equiv_o, disjoint_o, viol_order_o, viol_disj_o;
    logic [N-1:0]    illegal_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // reference model, written from the requirements
    bit m_rank [N][N];
    bit m_eq   [N][N];
    bit m_seen [N][N];   // i seen Off while j On
    bit m_vo   [N][N];
    bit m_vd   [N][N];
    bit m_bad  [N];

    always #4 clk = ~clk;

    island_order_monitor #(.N_ISL(N)) u_dut (
        .clk          (clk),
        .clear_i      (clear_i),
        .sample_en_i  (sample_en_i),
        .isl_state_i  (isl_state_i),
        .ctrl_conn_i  (ctrl_conn_i),
        .rank_over_o  (rank_over_o),
        .equiv_o      (equiv_o),
        .disjoint_o   (disjoint_o),
        .viol_order_o (viol_order_o),
        .viol_disj_o  (viol_disj_o),
        .illegal_o    (illegal_o)
    );

    function automatic logic [2*N-1:0] st(input logic [1:0] s0, s1, s2, s3);
        return {s3, s2, s1, s0};
    endfunction

    function automatic logic [NN-1:0] bitn(input int i, input int j);
        logic [NN-1:0] v = '0;
        v[i*N+j] = 1'b1;
        return v;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_bad[i] = 0;
            for (int j = 0; j < N; j++) begin
                m_rank[i][j] = (i != j);
                m_eq[i][j]   = (i != j);
                m_seen[i][j] = 0;
                m_vo[i][j]   = 0;
                m_vd[i][j]   = 0;
            end
        end
    endtask

    task automatic step(input logic [2*N-1:0] s, input logic en,
                        input logic [NN-1:0] cn, input logic clr);
        isl_state_i = s;
        sample_en_i = en;
        ctrl_conn_i = cn;
        clear_i     = clr;
        @(posedge clk);
        if (clr) begin
            model_clear();
        end else begin
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++)
                    if (i != j && cn[i*N+j]) begin
                        if (m_rank[j][i] && !m_rank[i][j]) m_vo[i][j] = 1;
                        if (m_seen[i][j] && m_seen[j][i]) m_vd[i][j] = 1;
                    end
            if (en) begin
                for (int i = 0; i < N; i++)
                    if (s[2*i +: 2] == BAD) m_bad[i] = 1;
                for (int i = 0; i < N; i++)
                    for (int j = 0; j < N; j++) begin
                        logic [1:0] ci, cj;
                        ci = s[2*i +: 2];
                        cj = s[2*j +: 2];
                        if (i != j && ci != BAD && cj != BAD) begin
                            if (ci < cj) m_rank[i][j] = 0;
                            if (ci != cj) m_eq[i][j] = 0;
                            if (ci == OFF && cj == ON) m_seen[i][j] = 1;
                        end
                    end
            end
        end
        @(negedge clk);
    endtask

    task automatic check_all(input string ctx);
        logic [NN-1:0] er, ee, ed, evo, evd;
        logic [N-1:0]  eb;
        for (int i = 0; i < N; i++) begin
            eb[i] = m_bad[i];
            for (int j = 0; j < N; j++) begin
                er[i*N+j]  = m_rank[i][j];
                ee[i*N+j]  = m_eq[i][j];
                ed[i*N+j]  = m_seen[i][j] & m_seen[j][i];
                evo[i*N+j] = m_vo[i][j];
                evd[i*N+j] = m_vd[i][j];
            end
        end
        chk("R3", {ctx, " rank"},     64'(rank_over_o),  64'(er));
        chk("R4", {ctx, " equiv"},    64'(equiv_o),      64'(ee));
        chk("R5", {ctx, " disjoint"}, 64'(disjoint_o),   64'(ed));
        chk("R7", {ctx, " viol_ord"}, 64'(viol_order_o), 64'(evo));
        chk("R8", {ctx, " viol_dj"},  64'(viol_disj_o),  64'(evd));
        chk("R1", {ctx, " illegal"},  64'(illegal_o),    64'(eb));
    endtask

    task automatic t_reset();
        step(st(ON, ON, ON, ON), 1'b0, '0, 1'b1);
        chk("R2", "equiv after clear", 64'(equiv_o), 64'(16'h7BDE));
        chk("R2", "rank after clear",  64'(rank_over_o), 64'(16'h7BDE));
        check_all("reset");
    endtask

    task automatic t_rank_example();
        step(st(ON, ON,   ON, ON), 1'b1, '0, 1'b0);
        step(st(ON, OFF,  ON, ON), 1'b1, '0, 1'b0);
        step(st(ON, SB,   ON, ON), 1'b1, '0, 1'b0);
        step(st(SB, OFF,  ON, ON), 1'b1, '0, 1'b0);
        chk("R3", "0 over 1", 64'(rank_over_o[0*N+1]), 64'd1);
        chk("R3", "1 over 0", 64'(rank_over_o[1*N+0]), 64'd0);
        chk("R4", "0,1 equiv", 64'(equiv_o[1]), 64'd0);
        chk("R4", "2,3 equiv", 64'(equiv_o[2*N+3]), 64'd1);
        check_all("rank");
    endtask

    task automatic t_enable_low();
        step(st(OFF, ON, OFF, ON), 1'b0, '0, 1'b0);
        chk("R6", "rank held", 64'(rank_over_o[0*N+1]), 64'd1);
        chk("R6", "equiv held", 64'(equiv_o[2*N+3]), 64'd1);
        check_all("noen");
    endtask

    task automatic t_order_viol();
        step(st(SB, OFF, ON, ON), 1'b1, bitn(1, 0) | bitn(0, 1), 1'b0);
        chk("R7", "1->0 flagged", 64'(viol_order_o[1*N+0]), 64'd1);
        chk("R7", "0->1 clean",   64'(viol_order_o[0*N+1]), 64'd0);
        step(st(SB, OFF, ON, ON), 1'b1, '0, 1'b0);
        chk("R7", "sticky", 64'(viol_order_o[1*N+0]), 64'd1);
        check_all("order");
    endtask

    task automatic t_disjoint();
        step(st(ON, ON, OFF, ON), 1'b1, '0, 1'b0);
        chk("R5", "one combo only", 64'(disjoint_o[2*N+3]), 64'd0);
        step(st(ON, ON, ON, OFF), 1'b1, '0, 1'b0);
        chk("R5", "both combos", 64'(disjoint_o[2*N+3]), 64'd1);
        step(st(ON, ON, ON, OFF), 1'b1, bitn(2, 3), 1'b0);
        chk("R8", "2->3 disjoint", 64'(viol_disj_o[2*N+3]), 64'd1);
        check_all("disj");
    endtask

    task automatic t_standby_only();
        step(st(ON, ON, ON, ON), 1'b0, '0, 1'b1);
        step(st(ON, ON, SB, ON), 1'b1, '0, 1'b0);
        step(st(ON, ON, ON, SB), 1'b1, '0, 1'b0);
        chk("R5", "standby crossing", 64'(disjoint_o[2*N+3]), 64'd0);
        chk("R3", "crossed no rank", 64'(rank_over_o[2*N+3] | rank_over_o[3*N+2]), 64'd0);
        check_all("stby");
    endtask

    task automatic t_diag_equal();
        step(st(ON, ON, ON, ON), 1'b0, '0, 1'b1);
        for (int k = 0; k < 3; k++) step(st(SB, SB, SB, SB), 1'b1, '1, 1'b0);
        chk("R9", "no order viol", 64'(viol_order_o), 64'd0);
        chk("R9", "no disj viol",  64'(viol_disj_o),  64'd0);
        check_all("diag");
    endtask

    task automatic t_timing();
        step(st(ON, ON, ON, ON), 1'b0, '0, 1'b1);
        step(st(ON, OFF, ON, ON), 1'b1, bitn(1, 0), 1'b0);
        chk("R10", "rank moved", 64'(rank_over_o[1*N+0]), 64'd0);
        chk("R10", "viol not yet", 64'(viol_order_o[1*N+0]), 64'd0);
        step(st(ON, OFF, ON, ON), 1'b0, bitn(1, 0), 1'b0);
        chk("R10", "viol next edge", 64'(viol_order_o[1*N+0]), 64'd1);
        check_all("timing");
    endtask

    task automatic t_illegal();
        step(st(ON, ON, ON, ON), 1'b0, '0, 1'b1);
        step(st(ON, ON, BAD, ON), 1'b0, '0, 1'b0);
        chk("R1", "unsampled bad", 64'(illegal_o), 64'd0);
        step(st(OFF, ON, ON, BAD), 1'b1, '0, 1'b0);
        chk("R1", "flag island 3", 64'(illegal_o), 64'h8);
        chk("R1", "pair 0,3 frozen", 64'(equiv_o[0*N+3]), 64'd1);
        chk("R1", "pair 0,1 updated", 64'(equiv_o[0*N+1]), 64'd0);
        step(st(ON, ON, ON, ON), 1'b1, '0, 1'b0);
        chk("R1", "flag sticky", 64'(illegal_o), 64'h8);
        check_all("illegal");
    endtask

    task automatic t_clear_wins();
        step(st(OFF, ON, SB, BAD), 1'b1, '1, 1'b1);
        chk("R2", "clear over sample", 64'(equiv_o), 64'(16'h7BDE));
        chk("R2", "illegal cleared", 64'(illegal_o), 64'd0);
        check_all("clrwin");
    endtask

    initial begin
        clear_i = 1'b1;
        sample_en_i = 1'b0;
        isl_state_i = '0;
        ctrl_conn_i = '0;
        model_clear();
        t_reset();
        t_rank_example();
        t_enable_low();
        t_order_viol();
        t_disjoint();
        t_standby_only();
        t_diag_equal();
        t_timing();
        t_illegal();
        t_clear_wins();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule